// File: doc/BRIEF.md
# Compare-Flag Condition Evaluator

This block turns the four status flags left behind by a compare, that is a subtraction of operand B from operand A, into a single take/not-take decision. It serves branch units, conditional-select logic and predication paths. The flags are negative (N), zero (Z), carry (C) and overflow (V). A 4-bit condition code picks the relation to test: equality, unsigned ordering, signed ordering, sign, overflow, always or never.

Unsigned ordering comes from C and Z. Signed ordering comes from whether N and V agree, plus Z. Carry alone cannot order signed values. For example, 0 compared with the 4-bit patterns 1000 to 1011 is unsigned-lower but signed-greater.

Flag producers differ in how they report carry on a subtraction. Some report a true carry-out, which is 1 when no borrow occurs. Others report a borrow, which is 1 when A is unsigned-lower than B. The parameter `BORROW_STYLE` selects which convention the incoming C flag follows, so that unsigned tests give the same answers either way. The block is purely combinational and holds no state.

The condition codes are arranged in pairs. An odd code is always the complement of the even code just below it.

Top module: `cond_eval`

## Requirements
- R1: Code 0000 (equal) takes exactly when Z=1; code 0001 (not equal) takes exactly when Z=0, regardless of signedness.
- R2: Code 0010 takes when A is unsigned-greater than B (carry-out 1 and Z=0); code 0011 takes when A is unsigned-lower-or-same (carry-out 0 or Z=1).
- R3: Code 0100 takes when A is unsigned-higher-or-same (carry-out 1); code 0101 takes when A is unsigned-lower (carry-out 0).
- R4: Code 0110 takes when A is signed-greater than B (N equals V and Z=0); code 0111 takes when A is signed-less-or-equal (Z=1 or N differs from V).
- R5: Code 1000 takes when A is signed-greater-or-equal (N equals V); code 1001 takes when A is signed-less (N differs from V); carry is not consulted.
- R6: Code 1010 takes when N=1 (negative); code 1011 takes when N=0 (positive or zero).
- R7: Code 1100 takes when V=1; code 1101 takes when V=0.
- R8: Code 1110 always takes; code 1111 never takes, whatever the flags.
- R9: With `BORROW_STYLE`=1 the C input is a borrow (1 when A is unsigned-lower), and every unsigned code gives the same decision for the same operands as the carry-style build with a true carry-out.
- R10: For every flag combination, the decision of each odd code is the complement of the decision of the even code below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flag_n | input | 1 | Negative flag: result sign bit of A minus B |
| flag_z | input | 1 | Zero flag: result of A minus B is zero |
| flag_c | input | 1 | Carry flag, carry-out or borrow per `BORROW_STYLE` |
| flag_v | input | 1 | Signed overflow flag of A minus B |
| cond_code | input | 4 | Condition selector, see requirements for encoding |
| take | output | 1 | 1 when the selected condition holds |

## Verification
Both the unsigned and the signed relations are always computed from the same flag set. The most telling case is one operand pair that gives opposite answers under the two readings, such as 0 against 1000 to 1011. For such a pair, the unsigned and signed codes must disagree in the expected direction.

The bench drives every 4-bit operand pair through an arithmetic subtractor model. For each pair it applies all sixteen codes to a carry-style build and a borrow-style build. Each decision is judged against integer comparisons of the operands read as unsigned and as two's-complement values, so both readings of the same flags are checked side by side.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  localparam int CODE_W = 4;
  localparam int BASE_W = CODE_W - 1;

  // Upper three code bits pick a base relation; bit 0 inverts it.
  typedef enum logic [BASE_W-1:0] {
    BASE_EQ  = 3'd0,
    BASE_UHI = 3'd1,
    BASE_UHS = 3'd2,
    BASE_SGT = 3'd3,
    BASE_SGE = 3'd4,
    BASE_NEG = 3'd5,
    BASE_OVS = 3'd6,
    BASE_ALW = 3'd7
  } base_cond_t;

endpackage

// File: rtl/cond_carry_norm.sv
module cond_carry_norm #(
  parameter bit BORROW_STYLE = 1'b0
) (
  input  logic c_in,
  output logic no_borrow
);
  // Normalise to "A is unsigned-higher-or-same".
  generate
    if (BORROW_STYLE) begin : g_borrow
      assign no_borrow = ~c_in;
    end else begin : g_carry
      assign no_borrow = c_in;
    end
  endgenerate
endmodule

// File: rtl/cond_unsigned.sv
module cond_unsigned (
  input  logic no_borrow,
  input  logic z,
  output logic u_hs,
  output logic u_hi
);
  assign u_hs = no_borrow;
  assign u_hi = no_borrow & ~z;

  always_comb begin
    AST_UHI_IMPLIES_UHS: assert (!u_hi || u_hs); // R2
  end
endmodule

// File: rtl/cond_signed.sv
module cond_signed (
  input  logic n,
  input  logic v,
  input  logic z,
  output logic s_ge,
  output logic s_gt
);
  assign s_ge = ~(n ^ v);
  assign s_gt = s_ge & ~z;

  always_comb begin
    AST_SGT_IMPLIES_SGE: assert (!s_gt || s_ge); // R4
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter bit BORROW_STYLE = 1'b0
) (
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic [CODE_W-1:0] cond_code,
  output logic              take
);
  logic       no_borrow;
  logic       u_hs, u_hi, s_ge, s_gt;
  logic       base_hit;
  base_cond_t base_sel;

  cond_carry_norm #(.BORROW_STYLE(BORROW_STYLE)) u_norm (
    .c_in      (flag_c),
    .no_borrow (no_borrow)
  );

  cond_unsigned u_uns (
    .no_borrow (no_borrow),
    .z         (flag_z),
    .u_hs      (u_hs),
    .u_hi      (u_hi)
  );

  cond_signed u_sgn (
    .n    (flag_n),
    .v    (flag_v),
    .z    (flag_z),
    .s_ge (s_ge),
    .s_gt (s_gt)
  );

  assign base_sel = base_cond_t'(cond_code[CODE_W-1:1]);

  always_comb begin
    unique case (base_sel)
      BASE_EQ:  base_hit = flag_z;
      BASE_UHI: base_hit = u_hi;
      BASE_UHS: base_hit = u_hs;
      BASE_SGT: base_hit = s_gt;
      BASE_SGE: base_hit = s_ge;
      BASE_NEG: base_hit = flag_n;
      BASE_OVS: base_hit = flag_v;
      BASE_ALW: base_hit = 1'b1;
      default:  base_hit = 1'b0;
    endcase
  end

  assign take = base_hit ^ cond_code[0];

  always_comb begin
    AST_EQ_FOLLOWS_Z: assert (cond_code != 4'b0000 || take == flag_z); // R1
    AST_ALWAYS_TAKES: assert (cond_code != 4'b1110 || take);           // R8
    AST_NEVER_TAKES:  assert (cond_code != 4'b1111 || !take);          // R8
    AST_PAIR_INVERTS: assert (!cond_code[0] || take == !base_hit);     // R10
  end
endmodule

// File: tb/cond_eval_tb.sv
module cond_eval_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       n, z, c_carry, c_borrow, v;
  logic [3:0] code;
  logic       take_c, take_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  cond_eval #(.BORROW_STYLE(1'b0)) u_dut (
    .flag_n(n), .flag_z(z), .flag_c(c_carry), .flag_v(v),
    .cond_code(code), .take(take_c)
  );

  cond_eval #(.BORROW_STYLE(1'b1)) u_dut_b (
    .flag_n(n), .flag_z(z), .flag_c(c_borrow), .flag_v(v),
    .cond_code(code), .take(take_b)
  );

  function automatic string req_of(input logic [3:0] k);
    case (k[3:1])
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic expect_take(input int ua, input int ub, input logic [3:0] k);
    int sa, sb;
    logic [3:0] d;
    sa = (ua >= 8) ? ua - 16 : ua;
    sb = (ub >= 8) ? ub - 16 : ub;
    d  = 4'(ua - ub);
    case (k)
      4'd0:  return ua == ub;
      4'd1:  return ua != ub;
      4'd2:  return ua > ub;
      4'd3:  return ua <= ub;
      4'd4:  return ua >= ub;
      4'd5:  return ua < ub;
      4'd6:  return sa > sb;
      4'd7:  return sa <= sb;
      4'd8:  return sa >= sb;
      4'd9:  return sa < sb;
      4'd10: return d[3];
      4'd11: return !d[3];
      4'd12: return (sa - sb > 7) || (sa - sb < -8);
      4'd13: return !((sa - sb > 7) || (sa - sb < -8));
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic prev_c;
    logic prev_b;
    n = 0; z = 0; c_carry = 0; c_borrow = 1; v = 0; code = '0;
    prev_c = 0;
    prev_b = 0;
    #(CLK_PERIOD);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [4:0] sum;
        sum = {1'b0, 4'(a)} + {1'b0, ~4'(b)} + 5'd1;
        n = sum[3];
        z = (sum[3:0] == 4'd0);
        c_carry  = sum[4];
        c_borrow = ~sum[4];
        v = (a[3] != b[3]) && (sum[3] != a[3]);
        for (int k = 0; k < 16; k++) begin
          logic e;
          code = 4'(k);
          #(CLK_PERIOD/5);
          e = expect_take(a, b, 4'(k));
          check(req_of(4'(k)), take_c, e, $sformatf("carry a=%0d b=%0d code=%0d", a, b, k));
          // R9: borrow-style build must match for the same operands
          check("R9", take_b, e, $sformatf("borrow a=%0d b=%0d code=%0d", a, b, k));
          // R10: odd code is complement of its even neighbour
          if (k % 2 == 1) begin
            check("R10", take_c, !prev_c, $sformatf("pair carry a=%0d b=%0d code=%0d", a, b, k));
            check("R10", take_b, !prev_b, $sformatf("pair borrow a=%0d b=%0d code=%0d", a, b, k));
          end
          prev_c = take_c;
          prev_b = take_b;
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule